// File: doc/BRIEF.md
# Synthesizer Loop Reference Divider and Phase Comparator

This block is the digital heart of a frequency synthesizer loop. It runs on the 75 kHz crystal clock and derives from it a reference strobe at one of six rates (25, 12.5, 6.25, 5, 3 or 1 kHz). A programmable divide-by-N counter consumes a one-cycle strobe per conditioned oscillator edge, `vco_tick`, which a front end outside this block supplies in step with the crystal clock. A phase/frequency comparator weighs the two strobes and drives a three-state charge-pump control: driven high when the divided oscillator leads, meaning it runs fast, driven low when the reference leads, and floating when the two agree.

The comparator keeps the pump floating for the first one or four clocks of every error, as chosen by the dead-band select. An error that outlasts a fixed limit latches a sticky out-of-lock flag, which software clears with a read strobe. While the loop is stopped, halted or in backup, the pump floats in that same cycle and every divider and the comparator are cleared. The flag is kept.

Top module: `pll_synth_core`

## Requirements
- R1: During and right after reset the pump floats (`pump_oe`=0, `pump_lvl`=0), `unlock_flag` is 0 and both strobes are low.
- R2: `ref_sel` codes 0,1,2,3,4,5 divide the clock by 75,25,15,12,6,3. Codes 6 and 7 divide by 75. `ref_tick` is a one-clock pulse repeating at that ratio.
- R3: `div_tick` pulses once, one clock after every N-th `vco_tick`. An `n_value` of 0 acts as 1. N is taken at the start of each division cycle.
- R4: When the divided oscillator strobe leads the reference by D clocks, the pump is driven high (`pump_oe`=1, `pump_lvl`=1) for D minus the dead band clocks.
- R5: When the reference leads by D clocks, the pump is driven low (`pump_oe`=1, `pump_lvl`=0) for D minus the dead band clocks.
- R6: Strobes that reach the comparator in the same clock leave the pump floating. `pump_lvl` is 0 whenever `pump_oe` is 0.
- R7: With `dz_mode`=0 the first clock of every error is withheld. With `dz_mode`=1 the first four are withheld. Shorter errors never drive the pump.
- R8: Whenever `pll_stop`, `halt` or `backup` is 1, `pump_oe` is 0 in that same cycle, and the dividers and comparator restart from cleared state.
- R9: An error that lasts more than 6 clocks sets `unlock_flag`. The flag holds through stop and later locked operation. A one-clock `unlock_rd` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 75 kHz crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sel | input | 3 | Reference rate code |
| n_value | input | 16 | Divide-by-N value |
| dz_mode | input | 1 | Dead band: 0 narrow, 1 wide |
| pll_stop | input | 1 | Loop stop |
| halt | input | 1 | Halt mode |
| backup | input | 1 | Backup mode |
| vco_tick | input | 1 | One-clock strobe per oscillator edge |
| unlock_rd | input | 1 | Read strobe that clears the flag |
| ref_tick | output | 1 | Reference strobe |
| div_tick | output | 1 | Divided oscillator strobe |
| pump_oe | output | 1 | Pump drive enable (0 = high impedance) |
| pump_lvl | output | 1 | Pump level while driven |
| unlock_flag | output | 1 | Sticky out-of-lock flag |

## Verification
The hardest condition to reach is a chosen phase offset of a known sign and length between the reference strobe and the divided strobe, since both come out of free-running counters. The stimulus first clears everything through stop and sets N to 1, so that every oscillator strobe becomes a divided strobe. It then waits for the first reference strobe and places oscillator strobes at fixed clock offsets from it, on both sides of the next reference strobe 75 clocks later. This yields exact lead, lag and coincident cases, including the dead-band and unlock limits.

// File: rtl/pll_synth_pkg.sv
package pll_synth_pkg;

    localparam int REF_SEL_W = 3;
    localparam int REF_CNT_W = 7;

    typedef enum logic [1:0] {
        PUMP_FLOAT = 2'd0,
        PUMP_SRC   = 2'd1,
        PUMP_SINK  = 2'd2
    } pump_e;

    function automatic logic [REF_CNT_W-1:0] ref_ratio(input logic [REF_SEL_W-1:0] code);
        logic [REF_CNT_W-1:0] r;
        case (code)
            3'd1:    r = REF_CNT_W'(25);
            3'd2:    r = REF_CNT_W'(15);
            3'd3:    r = REF_CNT_W'(12);
            3'd4:    r = REF_CNT_W'(6);
            3'd5:    r = REF_CNT_W'(3);
            default: r = REF_CNT_W'(75);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div
    import pll_synth_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en,
    input  logic [REF_SEL_W-1:0] sel,
    output logic                 tick
);

    typedef struct packed {
        logic [REF_CNT_W-1:0] cnt;
        logic                 tick;
    } ref_st_t;

    ref_st_t              st_q, st_d;
    logic [REF_CNT_W-1:0] last;

    always_comb begin
        st_d = st_q;
        last = ref_ratio(sel) - 1'b1;
        if (!run_en) begin
            st_d = '0;
        end else if (st_q.cnt >= last) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/pll_n_div.sv
module pll_n_div #(
    parameter int N_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic           vco_tick,
    input  logic [N_W-1:0] n_value,
    output logic           tick
);

    localparam logic [N_W-1:0] ONE = N_W'(1);

    typedef struct packed {
        logic [N_W-1:0] cnt;
        logic [N_W-1:0] hold;
        logic           tick;
    } ndiv_st_t;

    ndiv_st_t       st_q, st_d;
    logic [N_W-1:0] eff;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == '0) eff = (n_value == '0) ? ONE : n_value;
        else                eff = st_q.hold;
        if (!run_en) begin
            st_d = '0;
        end else if (vco_tick) begin
            if (st_q.cnt == '0) st_d.hold = eff;
            if (st_q.cnt + ONE >= eff) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd
    import pll_synth_pkg::*;
#(
    parameter int DZ_NARROW  = 1,
    parameter int DZ_WIDE    = 4,
    parameter int UNLOCK_CYC = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_en,
    input  logic  ref_tick,
    input  logic  div_tick,
    input  logic  dz_mode,
    input  logic  rd_clr,
    output pump_e pump,
    output logic  flag
);

    localparam int RUN_TOP = (UNLOCK_CYC > DZ_WIDE) ? UNLOCK_CYC : DZ_WIDE;
    localparam int RUN_W   = $clog2(RUN_TOP + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_TOP);
    localparam logic [RUN_W-1:0] THR_N   = RUN_W'(DZ_NARROW);
    localparam logic [RUN_W-1:0] THR_W   = RUN_W'(DZ_WIDE);
    localparam logic [RUN_W-1:0] THR_U   = RUN_W'(UNLOCK_CYC);

    typedef struct packed {
        logic             hi;
        logic             lo;
        logic [RUN_W-1:0] run;
        logic             flag;
    } pfd_st_t;

    pfd_st_t          st_q, st_d;
    logic             up_req, dn_req, both, err, drive, set_flag;
    logic [RUN_W-1:0] thr;

    always_comb begin
        st_d     = st_q;
        up_req   = st_q.hi | div_tick;
        dn_req   = st_q.lo | ref_tick;
        both     = up_req & dn_req;
        thr      = dz_mode ? THR_W : THR_N;
        err      = run_en & (st_q.hi | st_q.lo);
        drive    = err & (st_q.run >= thr);
        set_flag = err & (st_q.run >= THR_U);

        if (!run_en) begin
            st_d.hi  = 1'b0;
            st_d.lo  = 1'b0;
            st_d.run = '0;
        end else begin
            st_d.hi = up_req & ~both;
            st_d.lo = dn_req & ~both;
            if ((st_d.hi | st_d.lo) && (st_q.hi | st_q.lo))
                st_d.run = (st_q.run == RUN_MAX) ? st_q.run : st_q.run + 1'b1;
            else
                st_d.run = '0;
        end
        st_d.flag = set_flag | (st_q.flag & ~rd_clr);

        if (!drive)       pump = PUMP_FLOAT;
        else if (st_q.hi) pump = PUMP_SRC;
        else              pump = PUMP_SINK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
    import pll_synth_pkg::*;
#(
    parameter int N_W        = 16,
    parameter int DZ_NARROW  = 1,
    parameter int DZ_WIDE    = 4,
    parameter int UNLOCK_CYC = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REF_SEL_W-1:0] ref_sel,
    input  logic [N_W-1:0]       n_value,
    input  logic                 dz_mode,
    input  logic                 pll_stop,
    input  logic                 halt,
    input  logic                 backup,
    input  logic                 vco_tick,
    input  logic                 unlock_rd,
    output logic                 ref_tick,
    output logic                 div_tick,
    output logic                 pump_oe,
    output logic                 pump_lvl,
    output logic                 unlock_flag
);

    logic  active;
    pump_e pump;

    assign active = ~(pll_stop | halt | backup);

    pll_ref_div u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (active),
        .sel    (ref_sel),
        .tick   (ref_tick)
    );

    pll_n_div #(.N_W(N_W)) u_ndiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (active),
        .vco_tick (vco_tick),
        .n_value  (n_value),
        .tick     (div_tick)
    );

    pll_pfd #(
        .DZ_NARROW  (DZ_NARROW),
        .DZ_WIDE    (DZ_WIDE),
        .UNLOCK_CYC (UNLOCK_CYC)
    ) u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (active),
        .ref_tick (ref_tick),
        .div_tick (div_tick),
        .dz_mode  (dz_mode),
        .rd_clr   (unlock_rd),
        .pump     (pump),
        .flag     (unlock_flag)
    );

    assign pump_oe  = (pump != PUMP_FLOAT);
    assign pump_lvl = (pump == PUMP_SRC);

endmodule

// File: rtl/pll_synth_core_chk.sv
module pll_synth_core_chk (
    input logic clk,
    input logic rst_n,
    input logic pll_stop,
    input logic halt,
    input logic backup,
    input logic vco_tick,
    input logic unlock_rd,
    input logic ref_tick,
    input logic div_tick,
    input logic pump_oe,
    input logic pump_lvl,
    input logic unlock_flag
);

    a_r8_forced_float: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_stop || halt || backup) |-> !pump_oe);

    a_r2_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);

    a_r3_div_follows_vco: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |-> $past(vco_tick));

    a_r6_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_oe |-> !pump_lvl);

    a_r9_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlock_flag) |-> $past(unlock_rd));

    a_r9_set_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_flag) |-> $past(pump_oe));

endmodule

bind pll_synth_core pll_synth_core_chk u_chk (.*);

// File: tb/pll_synth_core_tb.sv
module pll_synth_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ref_sel = 3'd0;
    logic [15:0] n_value = 16'd1;
    logic        dz_mode = 1'b0;
    logic        pll_stop = 1'b0;
    logic        halt = 1'b0;
    logic        backup = 1'b0;
    logic        vco_tick = 1'b0;
    logic        unlock_rd = 1'b0;
    logic        ref_tick, div_tick, pump_oe, pump_lvl, unlock_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pll_synth_core u_dut (
        .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .n_value(n_value),
        .dz_mode(dz_mode), .pll_stop(pll_stop), .halt(halt), .backup(backup),
        .vco_tick(vco_tick), .unlock_rd(unlock_rd), .ref_tick(ref_tick),
        .div_tick(div_tick), .pump_oe(pump_oe), .pump_lvl(pump_lvl),
        .unlock_flag(unlock_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart();
        pll_stop = 1'b1;
        vco_tick = 1'b0;
        repeat (3) @(negedge clk);
        pll_stop = 1'b0;
    endtask

    task automatic wait_ref();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ref_tick) break;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", int'(pump_oe), 0);
        chk("R1 flag in reset", int'(unlock_flag), 0);
        chk("R1 strobes in reset", int'(ref_tick | div_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", int'(pump_oe), 0);
        chk("R1 lvl after reset", int'(pump_lvl), 0);
    endtask

    task automatic t_ref_period(input int sel, input int exp);
        int n;
        ref_sel = 3'(sel);
        restart();
        wait_ref();
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            if (ref_tick) break;
        end
        chk($sformatf("R2 ref period code %0d", sel), n, exp);
    endtask

    task automatic t_ndiv(input int nval, input int spacing, input int exp);
        int t1, t2;
        n_value = 16'(nval);
        restart();
        t1 = -1;
        t2 = -1;
        for (int k = 0; k < 600; k++) begin
            if (div_tick) begin
                if (t1 < 0) t1 = k;
                else if (t2 < 0) t2 = k;
            end
            vco_tick = (k % spacing) == 0;
            @(negedge clk);
        end
        vco_tick = 1'b0;
        chk($sformatf("R3 div interval N=%0d", nval), t2 - t1, exp);
    endtask

    task automatic t_pfd(input int gap, input int lead, input bit mode,
                         input int exp_lo, input int exp_hi, input int exp_flag,
                         input string req);
        int lo_n, hi_n;
        ref_sel = 3'd0;
        n_value = 16'd1;
        dz_mode = mode;
        pll_stop = 1'b1;
        unlock_rd = 1'b1;
        @(negedge clk);
        unlock_rd = 1'b0;
        restart();
        wait_ref();
        lo_n = 0;
        hi_n = 0;
        for (int k = 0; k <= 80; k++) begin
            if (k > 0) begin
                if (pump_oe && pump_lvl)  hi_n++;
                if (pump_oe && !pump_lvl) lo_n++;
            end
            vco_tick = (k == gap) || (k == 74 - lead);
            @(negedge clk);
        end
        vco_tick = 1'b0;
        chk({req, " low drive clocks"}, lo_n, exp_lo);
        chk({req, " high drive clocks"}, hi_n, exp_hi);
        chk({req, " unlock flag"}, int'(unlock_flag), exp_flag);
    endtask

    task automatic t_unlock_clear();
        t_pfd(7, 9, 1'b1, 4, 5, 1, "R9 long error");
        pll_stop = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 flag kept through stop", int'(unlock_flag), 1);
        unlock_rd = 1'b1;
        @(negedge clk);
        unlock_rd = 1'b0;
        chk("R9 flag cleared by read", int'(unlock_flag), 0);
        pll_stop = 1'b0;
    endtask

    task automatic t_force(input int which);
        ref_sel = 3'd0;
        n_value = 16'd1;
        dz_mode = 1'b0;
        restart();
        wait_ref();
        for (int k = 0; k < 10; k++) @(negedge clk);
        chk("R5 low drive before hold", int'(pump_oe && !pump_lvl), 1);
        if (which == 0) halt = 1'b1;
        else if (which == 1) backup = 1'b1;
        else pll_stop = 1'b1;
        #1;
        chk($sformatf("R8 float same cycle mode %0d", which), int'(pump_oe), 0);
        @(negedge clk);
        halt = 1'b0;
        backup = 1'b0;
        pll_stop = 1'b0;
        chk($sformatf("R8 float after hold mode %0d", which), int'(pump_oe), 0);
        repeat (3) @(negedge clk);
        chk($sformatf("R8 detector cleared mode %0d", which), int'(pump_oe), 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ref_period(0, 75);
        t_ref_period(1, 25);
        t_ref_period(2, 15);
        t_ref_period(3, 12);
        t_ref_period(4, 6);
        t_ref_period(5, 3);
        t_ref_period(6, 75);
        t_ref_period(7, 75);
        t_ndiv(5, 1, 5);
        t_ndiv(3, 2, 6);
        t_ndiv(0, 1, 1);
        t_ndiv(1, 3, 3);
        t_pfd(0, 0, 1'b0, 0, 0, 0, "R6 coincident");
        t_pfd(3, 0, 1'b0, 3, 0, 0, "R5 reference leads");
        t_pfd(0, 5, 1'b0, 0, 4, 0, "R4 divided leads");
        t_pfd(3, 0, 1'b1, 0, 0, 0, "R7 wide band swallows");
        t_pfd(0, 6, 1'b1, 0, 2, 0, "R7 wide band trims");
        t_pfd(5, 0, 1'b0, 5, 0, 0, "R9 six clock error");
        t_pfd(6, 0, 1'b0, 6, 0, 1, "R9 seven clock error");
        t_unlock_clear();
        t_force(0);
        t_force(1);
        t_force(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule